// File: doc/BRIEF.md
# Operand-Verified Retirement Gate

This block keeps two completion flags for every reorder-buffer slot, one for each possible source operand. A flag is set when its operand read went unprotected by the ECC side table, or when the ECC check of that operand's read has finished. An instruction may leave the head of the reorder buffer only when both of its flags are set. Retirement is therefore held back until the verification of every register value the instruction consumed has finished.

Dispatch writes the starting flags of each new slot from the number of register sources the instruction has. Read-status and check-completion events then set single flags, each addressed by buffer index and operand slot. Every cycle the gate looks at up to `RET_W` consecutive entries starting at the head. It grants retirement to the longest run of ready entries, and it stops at the first entry that is not ready. When the buffer reports itself full, the oldest entry is granted regardless of its flags, which keeps a slow check from stalling the machine. A clear input empties all flags during a recovery flush.

Top module: `retire_gate`

## Requirements
- R1: After reset every flag is clear, so with the buffer not full no head entry is granted.
- R2: Dispatch with a source count of 2 (or the unused code 3) leaves both flags of the slot clear, overwriting any earlier state of that slot.
- R3: Dispatch with a source count of 1 sets the flag of operand slot 1 and leaves operand slot 0 clear.
- R4: Dispatch with a source count of 0 sets both flags, so the entry is ready at once.
- R5: A read-status event with the protected bit low sets the addressed flag (slot bit 0 means operand 0, 1 means operand 1). With the protected bit high it changes nothing.
- R6: A check-completion event sets the flag of the addressed entry and operand slot.
- R7: Grant bit k of `retire_ok_o` refers to the entry at distance k from the head. It is high only when both flags of that entry and of every older entry in the window are set. The grants form a contiguous run starting at bit 0.
- R8: While `rob_full_i` is high, the oldest entry is granted whatever its flags. Younger entries still need both of their own flags set.
- R9: No more entries are granted than `head_avail_i` reports. Window positions wrap from the last index back to index 0.
- R10: A clear empties every flag and overrides any dispatch or set event in the same cycle.
- R11: `retire_cnt_o` equals the number of granted entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr_i | input | 1 | Recovery flush: empty all flags |
| disp_vld_i | input | DSP_W | Dispatch lane valid |
| disp_idx_i | input | DSP_W x IDX_W | Buffer index written by each dispatch lane |
| disp_nsrc_i | input | DSP_W x 2 | Register source count of each dispatched instruction |
| rd_vld_i | input | RD_W | Read-status event valid |
| rd_idx_i | input | RD_W x IDX_W | Buffer index of the reading instruction |
| rd_slot_i | input | RD_W | Operand slot of the read |
| rd_prot_i | input | RD_W | High when the read register was covered by the ECC table |
| chk_vld_i | input | CHK_W | Check-completion event valid |
| chk_idx_i | input | CHK_W x IDX_W | Buffer index of the checked instruction |
| chk_slot_i | input | CHK_W | Operand slot that finished its check |
| head_idx_i | input | IDX_W | Index of the oldest entry |
| head_avail_i | input | CNT_W | Number of occupied entries from the head, at most RET_W |
| rob_full_i | input | 1 | Buffer full: oldest entry retires unconditionally |
| retire_ok_o | output | RET_W | Grant per window position |
| retire_cnt_o | output | CNT_W | Number of granted entries |

## Verification
Dispatch, read-status, check and clear events act on the flags at the clock edge that samples them, and the flags are visible from the following cycle. Grants and the count are pure combinational functions of the stored flags and of the head, availability and full inputs, so they follow those inputs within the same cycle. The bench applies each event during one low clock phase and lets one rising edge pass. It then changes only the head-side inputs and samples just after the falling edge. The sweep covers every head position, all 64 flag patterns over the three-entry window, every availability count and both states of the full signal.

// File: rtl/retire_gate_pkg.sv
package retire_gate_pkg;

  typedef logic [1:0] fin_t;

  localparam fin_t FIN_DONE = 2'b11;

  // Starting flags for a freshly dispatched instruction; bit 0 is operand 0.
  function automatic fin_t fin_at_dispatch(input logic [1:0] nsrc);
    fin_t r;
    case (nsrc)
      2'd0:    r = 2'b11;
      2'd1:    r = 2'b10;
      default: r = 2'b00;
    endcase
    return r;
  endfunction

  // Circular index step; base must be below size.
  function automatic int unsigned ring_add(input int unsigned base,
                                           input int unsigned off,
                                           input int unsigned size);
    int unsigned s;
    s = base + off;
    return (s >= size) ? (s - size) : s;
  endfunction

endpackage

// File: rtl/rg_set_decode.sv
module rg_set_decode #(
  parameter int ENTRIES = 126,
  parameter int IDX_W   = 7,
  parameter int RD_W    = 6,
  parameter int CHK_W   = 2
) (
  input  logic [RD_W-1:0]              rd_vld_i,
  input  logic [RD_W-1:0][IDX_W-1:0]   rd_idx_i,
  input  logic [RD_W-1:0]              rd_slot_i,
  input  logic [RD_W-1:0]              rd_prot_i,
  input  logic [CHK_W-1:0]             chk_vld_i,
  input  logic [CHK_W-1:0][IDX_W-1:0]  chk_idx_i,
  input  logic [CHK_W-1:0]             chk_slot_i,
  output logic [ENTRIES-1:0][1:0]      set_o
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [1:0] acc;

    always_comb begin
      acc = 2'b00;
      for (int p = 0; p < RD_W; p++) begin
        if (rd_vld_i[p] && !rd_prot_i[p] && (rd_idx_i[p] == IDX_W'(e)))
          acc[rd_slot_i[p]] = 1'b1;
      end
      for (int c = 0; c < CHK_W; c++) begin
        if (chk_vld_i[c] && (chk_idx_i[c] == IDX_W'(e)))
          acc[chk_slot_i[c]] = 1'b1;
      end
    end

    assign set_o[e] = acc;
  end

endmodule

// File: rtl/rg_flag_bank.sv
module rg_flag_bank
  import retire_gate_pkg::*;
#(
  parameter int ENTRIES = 126,
  parameter int IDX_W   = 7,
  parameter int DSP_W   = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr_i,
  input  logic [DSP_W-1:0]             disp_vld_i,
  input  logic [DSP_W-1:0][IDX_W-1:0]  disp_idx_i,
  input  logic [DSP_W-1:0][1:0]        disp_nsrc_i,
  input  logic [ENTRIES-1:0][1:0]      set_i,
  output logic [ENTRIES-1:0][1:0]      fin_q
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    fin_t fin_d;
    logic fin_en;

    // Next state: clear beats dispatch, dispatch is applied before set events.
    always_comb begin
      fin_t base;
      logic hit;
      base = fin_q[e];
      hit  = 1'b0;
      for (int d = 0; d < DSP_W; d++) begin
        if (disp_vld_i[d] && (disp_idx_i[d] == IDX_W'(e))) begin
          base = fin_at_dispatch(disp_nsrc_i[d]);
          hit  = 1'b1;
        end
      end
      if (clr_i) begin
        fin_d = 2'b00;
      end else begin
        fin_d = base | set_i[e];
      end
      fin_en = clr_i | hit | (|set_i[e]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fin_q[e] <= 2'b00;
      end else if (fin_en) begin
        fin_q[e] <= fin_d;
      end
    end
  end

endmodule

// File: rtl/rg_head_gate.sv
module rg_head_gate
  import retire_gate_pkg::*;
#(
  parameter int ENTRIES = 126,
  parameter int IDX_W   = 7,
  parameter int RET_W   = 3,
  parameter int CNT_W   = 2
) (
  input  logic [ENTRIES-1:0][1:0] fin_q,
  input  logic [IDX_W-1:0]        head_idx_i,
  input  logic [CNT_W-1:0]        head_avail_i,
  input  logic                    rob_full_i,
  output logic [RET_W-1:0]        retire_ok_o,
  output logic [CNT_W-1:0]        retire_cnt_o
);

  logic [RET_W-1:0] ready;
  logic [RET_W-1:0] inwin;

  for (genvar k = 0; k < RET_W; k++) begin : g_pos
    logic [IDX_W-1:0] pos_idx;
    logic             ovr;

    assign pos_idx = IDX_W'(ring_add(32'(head_idx_i), k, ENTRIES));

    if (k == 0) begin : g_old
      assign ovr = rob_full_i;
    end else begin : g_young
      assign ovr = 1'b0;
    end

    assign ready[k] = (fin_q[pos_idx] == FIN_DONE) | ovr;
    assign inwin[k] = (CNT_W'(k) < head_avail_i);

    if (k == 0) begin : g_first
      assign retire_ok_o[k] = ready[k] & inwin[k];
    end else begin : g_chain
      assign retire_ok_o[k] = ready[k] & inwin[k] & retire_ok_o[k-1];
    end
  end

  // Count built by a separate first-failure scan.
  always_comb begin
    logic stop;
    stop         = 1'b0;
    retire_cnt_o = '0;
    for (int k = 0; k < RET_W; k++) begin
      if (!stop && ready[k] && inwin[k]) begin
        retire_cnt_o = retire_cnt_o + CNT_W'(1);
      end else begin
        stop = 1'b1;
      end
    end
  end

endmodule

// File: rtl/retire_gate.sv
module retire_gate #(
  parameter int ENTRIES = 126,
  parameter int RET_W   = 3,
  parameter int DSP_W   = 3,
  parameter int RD_W    = 6,
  parameter int CHK_W   = 2,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int CNT_W  = $clog2(RET_W + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr_i,
  input  logic [DSP_W-1:0]             disp_vld_i,
  input  logic [DSP_W-1:0][IDX_W-1:0]  disp_idx_i,
  input  logic [DSP_W-1:0][1:0]        disp_nsrc_i,
  input  logic [RD_W-1:0]              rd_vld_i,
  input  logic [RD_W-1:0][IDX_W-1:0]   rd_idx_i,
  input  logic [RD_W-1:0]              rd_slot_i,
  input  logic [RD_W-1:0]              rd_prot_i,
  input  logic [CHK_W-1:0]             chk_vld_i,
  input  logic [CHK_W-1:0][IDX_W-1:0]  chk_idx_i,
  input  logic [CHK_W-1:0]             chk_slot_i,
  input  logic [IDX_W-1:0]             head_idx_i,
  input  logic [CNT_W-1:0]             head_avail_i,
  input  logic                         rob_full_i,
  output logic [RET_W-1:0]             retire_ok_o,
  output logic [CNT_W-1:0]             retire_cnt_o
);

  logic [ENTRIES-1:0][1:0] set_v;
  logic [ENTRIES-1:0][1:0] fin_q;

  rg_set_decode #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .RD_W(RD_W), .CHK_W(CHK_W)
  ) u_dec (
    .rd_vld_i  (rd_vld_i),
    .rd_idx_i  (rd_idx_i),
    .rd_slot_i (rd_slot_i),
    .rd_prot_i (rd_prot_i),
    .chk_vld_i (chk_vld_i),
    .chk_idx_i (chk_idx_i),
    .chk_slot_i(chk_slot_i),
    .set_o     (set_v)
  );

  rg_flag_bank #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .DSP_W(DSP_W)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .disp_vld_i (disp_vld_i),
    .disp_idx_i (disp_idx_i),
    .disp_nsrc_i(disp_nsrc_i),
    .set_i      (set_v),
    .fin_q      (fin_q)
  );

  rg_head_gate #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .RET_W(RET_W), .CNT_W(CNT_W)
  ) u_gate (
    .fin_q       (fin_q),
    .head_idx_i  (head_idx_i),
    .head_avail_i(head_avail_i),
    .rob_full_i  (rob_full_i),
    .retire_ok_o (retire_ok_o),
    .retire_cnt_o(retire_cnt_o)
  );

endmodule

// File: rtl/retire_gate_chk.sv
module retire_gate_chk #(
  parameter int ENTRIES = 126,
  parameter int RET_W   = 3,
  parameter int DSP_W   = 3,
  parameter int CHK_W   = 2,
  parameter int IDX_W   = 7,
  parameter int CNT_W   = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         clr_i,
  input logic [DSP_W-1:0]             disp_vld_i,
  input logic [DSP_W-1:0][IDX_W-1:0]  disp_idx_i,
  input logic [DSP_W-1:0][1:0]        disp_nsrc_i,
  input logic [CHK_W-1:0]             chk_vld_i,
  input logic [CHK_W-1:0][IDX_W-1:0]  chk_idx_i,
  input logic [CHK_W-1:0]             chk_slot_i,
  input logic [IDX_W-1:0]             head_idx_i,
  input logic [CNT_W-1:0]             head_avail_i,
  input logic                         rob_full_i,
  input logic [RET_W-1:0]             retire_ok_o,
  input logic [CNT_W-1:0]             retire_cnt_o,
  input logic [ENTRIES-1:0][1:0]      fin_q
);

  localparam logic [IDX_W:0] LIM = (IDX_W+1)'(ENTRIES);

  // R4: zero-source dispatch on lane 0 (with no later lane on the same slot) is ready next cycle
  p_zero_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_vld_i == DSP_W'(1)) && (disp_nsrc_i[0] == 2'd0) && !clr_i &&
    ({1'b0, disp_idx_i[0]} < LIM)
    |=> fin_q[$past(disp_idx_i[0])] == 2'b11);

  p_chk_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_vld_i[0] && !clr_i && ({1'b0, chk_idx_i[0]} < LIM)
    |=> fin_q[$past(chk_idx_i[0])][$past(chk_slot_i[0])]);

  p_head_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    retire_ok_o[0] && !rob_full_i && ({1'b0, head_idx_i} < LIM)
    |-> fin_q[head_idx_i] == 2'b11);

  p_full_ovr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rob_full_i && (head_avail_i != '0) |-> retire_ok_o[0]);

  p_avail_lim_r9: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'($countones(retire_ok_o)) <= head_avail_i);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (fin_q == '0));

  p_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
    retire_cnt_o == CNT_W'($countones(retire_ok_o)));

endmodule

bind retire_gate retire_gate_chk #(
  .ENTRIES(ENTRIES), .RET_W(RET_W), .DSP_W(DSP_W), .CHK_W(CHK_W),
  .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr_i       (clr_i),
  .disp_vld_i  (disp_vld_i),
  .disp_idx_i  (disp_idx_i),
  .disp_nsrc_i (disp_nsrc_i),
  .chk_vld_i   (chk_vld_i),
  .chk_idx_i   (chk_idx_i),
  .chk_slot_i  (chk_slot_i),
  .head_idx_i  (head_idx_i),
  .head_avail_i(head_avail_i),
  .rob_full_i  (rob_full_i),
  .retire_ok_o (retire_ok_o),
  .retire_cnt_o(retire_cnt_o),
  .fin_q       (fin_q)
);

// File: tb/retire_gate_test.sv
`timescale 1ns/1ps
module retire_gate_test;

  localparam int ENT   = 6;
  localparam int RW    = 3;
  localparam int DW    = 3;
  localparam int RDW   = 3;
  localparam int CW    = 3;
  localparam int IW    = 3;
  localparam int CNW   = 2;

  logic               clk;
  logic               rst_n;
  logic               clr_i;
  logic [DW-1:0]      disp_vld_i;
  logic [DW-1:0][IW-1:0] disp_idx_i;
  logic [DW-1:0][1:0] disp_nsrc_i;
  logic [RDW-1:0]     rd_vld_i;
  logic [RDW-1:0][IW-1:0] rd_idx_i;
  logic [RDW-1:0]     rd_slot_i;
  logic [RDW-1:0]     rd_prot_i;
  logic [CW-1:0]      chk_vld_i;
  logic [CW-1:0][IW-1:0] chk_idx_i;
  logic [CW-1:0]      chk_slot_i;
  logic [IW-1:0]      head_idx_i;
  logic [CNW-1:0]     head_avail_i;
  logic               rob_full_i;
  logic [RW-1:0]      retire_ok_o;
  logic [CNW-1:0]     retire_cnt_o;

  int n_checks = 0;
  int n_errors = 0;

  retire_gate #(
    .ENTRIES(ENT), .RET_W(RW), .DSP_W(DW), .RD_W(RDW), .CHK_W(CW)
  ) uut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic idle();
    clr_i = 0; disp_vld_i = '0; disp_idx_i = '0; disp_nsrc_i = '0;
    rd_vld_i = '0; rd_idx_i = '0; rd_slot_i = '0; rd_prot_i = '0;
    chk_vld_i = '0; chk_idx_i = '0; chk_slot_i = '0;
  endtask

  // Apply current event inputs for exactly one rising edge.
  task automatic pulse();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic check(input string req, input logic [2:0] em, input logic [1:0] ec);
    #1;
    n_checks++;
    if (retire_ok_o !== em || retire_cnt_o !== ec) begin
      n_errors++;
      $display("FAIL %s: mask=%b cnt=%0d expected mask=%b cnt=%0d",
               req, retire_ok_o, retire_cnt_o, em, ec);
    end
  endtask

  task automatic view(input int h, input int av, input logic full);
    head_idx_i = IW'(h); head_avail_i = CNW'(av); rob_full_i = full;
  endtask

  initial begin
    #(200000 * 10);
    n_errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    idle();
    view(0, 0, 0);
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1: reset leaves all flags clear
    view(0, 3, 0); check("R1", 3'b000, 2'd0);
    view(3, 3, 0); check("R1", 3'b000, 2'd0);

    // R4: zero sources -> ready immediately after dispatch
    disp_vld_i = 3'b001; disp_idx_i[0] = 3'd0; disp_nsrc_i[0] = 2'd0;
    pulse();
    view(0, 1, 0); check("R4", 3'b001, 2'd1);

    // R3: one source -> slot1 set, slot0 clear
    disp_vld_i = 3'b001; disp_idx_i[0] = 3'd1; disp_nsrc_i[0] = 2'd1;
    pulse();
    view(1, 1, 0); check("R3", 3'b000, 2'd0);
    rd_vld_i = 3'b001; rd_idx_i[0] = 3'd1; rd_slot_i[0] = 1'b0; rd_prot_i[0] = 1'b0;
    pulse();
    view(1, 1, 0); check("R3", 3'b001, 2'd1);

    // R2: two sources (code 3) overwrites a ready slot with cleared flags
    disp_vld_i = 3'b001; disp_idx_i[0] = 3'd0; disp_nsrc_i[0] = 2'd3;
    pulse();
    view(0, 1, 0); check("R2", 3'b000, 2'd0);

    // R5: protected read does not set, unprotected read does
    rd_vld_i = 3'b001; rd_idx_i[0] = 3'd0; rd_slot_i[0] = 1'b0; rd_prot_i[0] = 1'b1;
    chk_vld_i = 3'b001; chk_idx_i[0] = 3'd0; chk_slot_i[0] = 1'b1;
    pulse();
    view(0, 1, 0); check("R5", 3'b000, 2'd0);

    // R6: check completion on slot0 finishes the entry
    chk_vld_i = 3'b001; chk_idx_i[0] = 3'd0; chk_slot_i[0] = 1'b0;
    pulse();
    view(0, 1, 0); check("R6", 3'b001, 2'd1);

    // R10: clear beats same-cycle dispatch and check events
    disp_vld_i = 3'b111;
    for (int j = 0; j < 3; j++) begin disp_idx_i[j] = IW'(j + 2); disp_nsrc_i[j] = 2'd0; end
    pulse();
    view(2, 3, 0); check("R10", 3'b111, 2'd3);
    clr_i = 1'b1;
    disp_vld_i = 3'b001; disp_idx_i[0] = 3'd5; disp_nsrc_i[0] = 2'd0;
    chk_vld_i = 3'b011; chk_idx_i[0] = 3'd2; chk_slot_i[0] = 1'b0;
    chk_idx_i[1] = 3'd2; chk_slot_i[1] = 1'b1;
    pulse();
    view(2, 3, 0); check("R10", 3'b000, 2'd0);
    view(4, 3, 0); check("R10", 3'b000, 2'd0);
    view(2, 3, 1); check("R10", 3'b001, 2'd1);

    // Sweep: every head (wrap, R9), every flag pattern, availability and full state.
    for (int h = 0; h < ENT; h++) begin
      for (int pat = 0; pat < 64; pat++) begin
        disp_vld_i = 3'b111;
        for (int j = 0; j < 3; j++) begin
          disp_idx_i[j] = IW'((h + j) % ENT); disp_nsrc_i[j] = 2'd2;
        end
        pulse();
        for (int j = 0; j < 3; j++) begin
          // operand 0 via a read event (protected when it must stay clear, R5)
          rd_vld_i[j] = 1'b1; rd_idx_i[j] = IW'((h + j) % ENT);
          rd_slot_i[j] = 1'b0; rd_prot_i[j] = ~pat[2*j];
          // operand 1 via a check completion (R6)
          chk_vld_i[j] = pat[2*j+1]; chk_idx_i[j] = IW'((h + j) % ENT);
          chk_slot_i[j] = 1'b1;
        end
        pulse();
        for (int full = 0; full < 2; full++) begin
          for (int av = 0; av <= RW; av++) begin
            logic [2:0] em;
            logic [1:0] ec;
            logic stop;
            em = '0; ec = '0; stop = 0;
            for (int k = 0; k < RW; k++) begin
              logic dn;
              dn = (((pat >> (2*k)) & 3) == 3) || (k == 0 && full == 1);
              if (!stop && k < av && dn) begin em[k] = 1'b1; ec = ec + 2'd1; end
              else stop = 1;
            end
            view(h, av, full[0]);
            check(full == 1 ? "R8 R9 R11" : "R7 R9 R11", em, ec);
          end
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule